// File: doc/BRIEF.md
# Multi-Source Reset Sequencer with Cause Flags

This block generates the synchronous internal reset for a small microcontroller core. Three things can start a reset. The first is an external reset pin. The second is a power-on event, which arrives as the active-low `porN` input. The third is a one-clock reset request from the watchdog. The clock is divided into machine cycles of four clocks. The pin is examined only on the last clock of each machine cycle, and a pin reset is accepted only after two such samples in a row read high.

When the last source goes away, the internal reset is kept asserted for two further machine cycles before it is released. On the clock after release, the block gives the core a one-clock strobe that loads the program counter with zero. If the reset episode began with power-on, the block also gives a one-clock strobe that turns the watchdog off.

Two sticky cause flags record power-on and watchdog resets. An external reset leaves no flag, so software treats "both flags clear" as an external reset. Software reads the flags through a small register port and clears them by writing zeros.

Top module: `rst_sequencer`

## Requirements
- R1: A machine cycle is four clocks. Counting rising edges after `porN` rises as 1, 2, 3 and so on, the pin is sampled only on edges whose number is a multiple of 4. A pin level present only between those edges has no effect on `coreRst`.
- R2: A pin reset is accepted at the second of two consecutive sampling edges that both see `rstPin` high. `coreRst` is high after that edge. A pulse that covers only one sampling edge never asserts `coreRst`.
- R3: While the sampled pin stays high, `coreRst` stays high. The first sampling edge that sees the pin low ends the pin source at the edge before it. `coreRst` then falls on the 8th edge after the last edge at which a source was present.
- R4: A `wdtRstReq` pulse at any edge, whatever the phase, makes `coreRst` high after that edge. `coreRst` falls on the 8th edge after the pulse.
- R5: While `porN` is low, `coreRst` is 1, `flagRd` is 8'h01 and both strobes are 0. The machine-cycle phase restarts, so the first edge after `porN` rises is edge 1. `coreRst` falls on edge 8.
- R6: `pcLoadZero` is high for exactly the one clock that follows the edge at which `coreRst` falls, after a reset from any source. It is low at all other times.
- R7: `wdtDisable` pulses together with `pcLoadZero` only when the reset episode began with power-on. It stays 0 after pin and watchdog resets.
- R8: `flagRd` reads {6'b0, watchdog flag (bit 1), power-on flag (bit 0)}. A watchdog request sets bit 1 at its edge. A pin reset sets no flag.
- R9: A write with `regWrEn` high clears each flag whose data bit is 0. A data bit of 1 leaves its flag unchanged. A watchdog request at the same edge as a clearing write leaves bit 1 set.
- R10: Both flags keep their values through pin and watchdog resets. Only power-on changes them without a write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| porN | input | 1 | Active-low power-on event, asynchronous assert |
| rstPin | input | 1 | External reset pin, active high |
| wdtRstReq | input | 1 | One-clock watchdog reset request |
| regWrEn | input | 1 | Flag register write strobe |
| regWrData | input | 8 | Write data; a 0 bit clears the matching flag |
| flagRd | output | 8 | Flag readback {6'b0, watchdog, power-on} |
| coreRst | output | 1 | Internal synchronous reset to the core |
| pcLoadZero | output | 1 | One-clock strobe to load the program counter with zero |
| wdtDisable | output | 1 | One-clock strobe to disable the watchdog after power-on |

## Verification
The hardest cases to reach from the ports are pin pulses whose alignment against the hidden four-clock phase decides whether one or two sampling edges see them. A pulse one clock too short or one clock too early must be rejected. The bench counts edges from the release of `porN` to know the phase. It sweeps every start phase against pulse lengths from 1 to 12 clocks, plus one long pulse. For each case it computes the rise and fall edges arithmetically and compares `coreRst` and `pcLoadZero` on every clock. Watchdog pulses are swept over all four phases. A watchdog request is also placed on the same edge as a clearing write, which exercises the priority between setting and clearing a flag.

// File: rtl/rst_seq_pkg.sv
package rst_seq_pkg;

  // Strobes passed from the sequencing control to the flag datapath
  typedef struct packed {
    logic wdtHit;      // watchdog request seen this edge
    logic releaseNow;  // internal reset drops at this edge
  } seqStrobe_t;

endpackage

// File: rtl/rst_seq_phase.sv
module rst_seq_phase #(
  parameter int STATES = 4
) (
  input  logic clk,
  input  logic porN,
  output logic lastState
);
  localparam int SW = (STATES > 1) ? $clog2(STATES) : 1;
  localparam logic [SW-1:0] LAST = SW'(STATES - 1);

  logic [SW-1:0] stateQ;

  // Free-running machine-cycle phase; only power-on restarts it
  always_ff @(posedge clk or negedge porN) begin
    if (!porN)               stateQ <= '0;
    else if (stateQ == LAST) stateQ <= '0;
    else                     stateQ <= stateQ + 1'b1;
  end

  assign lastState = (stateQ == LAST);
endmodule

// File: rtl/rst_seq_ctrl.sv
module rst_seq_ctrl
  import rst_seq_pkg::*;
#(
  parameter int STATES  = 4,
  parameter int CONFIRM = 2,
  parameter int HOLD_MC = 2
) (
  input  logic       clk,
  input  logic       porN,
  input  logic       sampleEdge,
  input  logic       rstPin,
  input  logic       wdtRstReq,
  output logic       coreRst,
  output seqStrobe_t strobes
);
  localparam int HOLD_CLKS = HOLD_MC * STATES;
  localparam int HW = $clog2(HOLD_CLKS + 1);
  localparam int CW = $clog2(CONFIRM + 1);
  localparam logic [CW-1:0] CONF_MAX = CW'(CONFIRM);
  localparam logic [HW-1:0] HOLD_INIT = HW'(HOLD_CLKS);

  logic [CW-1:0] seenQ, seenNext;
  logic [HW-1:0] holdQ;
  logic          rstQ;
  logic          extActive, srcNow, releaseNow;

  // Consecutive high samples of the pin, updated only on the sampling edge
  always_comb begin
    seenNext = seenQ;
    if (sampleEdge) begin
      if (!rstPin)               seenNext = '0;
      else if (seenQ < CONF_MAX) seenNext = seenQ + 1'b1;
    end
  end

  assign extActive  = (seenNext == CONF_MAX);
  assign srcNow     = extActive | wdtRstReq;
  assign releaseNow = !srcNow && (holdQ == HW'(1));

  always_ff @(posedge clk or negedge porN) begin
    if (!porN) begin
      seenQ <= '0;
      holdQ <= HOLD_INIT;
      rstQ  <= 1'b1;
    end else begin
      seenQ <= seenNext;
      if (srcNow) begin
        holdQ <= HOLD_INIT;
        rstQ  <= 1'b1;
      end else if (holdQ != '0) begin
        holdQ <= holdQ - 1'b1;
        if (releaseNow) rstQ <= 1'b0;
      end
    end
  end

  assign coreRst            = rstQ;
  assign strobes.wdtHit     = wdtRstReq;
  assign strobes.releaseNow = releaseNow;
endmodule

// File: rtl/rst_seq_flags.sv
module rst_seq_flags
  import rst_seq_pkg::*;
#(
  parameter int FLAG_W = 8
) (
  input  logic              clk,
  input  logic              porN,
  input  seqStrobe_t        strobes,
  input  logic              regWrEn,
  input  logic [FLAG_W-1:0] regWrData,
  output logic [FLAG_W-1:0] flagRd,
  output logic              pcLoadZero,
  output logic              wdtDisable
);
  localparam int POR_BIT = 0;
  localparam int WDT_BIT = 1;

  logic porFlag, wdtFlag, porEpisode, pcQ, wdQ;

  always_ff @(posedge clk or negedge porN) begin
    if (!porN) begin
      porFlag    <= 1'b1;
      wdtFlag    <= 1'b0;
      porEpisode <= 1'b1;
      pcQ        <= 1'b0;
      wdQ        <= 1'b0;
    end else begin
      if (regWrEn && !regWrData[POR_BIT]) porFlag <= 1'b0;
      // a set at the same edge outranks the clearing write
      if (strobes.wdtHit)                          wdtFlag <= 1'b1;
      else if (regWrEn && !regWrData[WDT_BIT])     wdtFlag <= 1'b0;
      if (strobes.releaseNow) porEpisode <= 1'b0;
      pcQ <= strobes.releaseNow;
      wdQ <= strobes.releaseNow & porEpisode;
    end
  end

  always_comb begin
    flagRd          = '0;
    flagRd[POR_BIT] = porFlag;
    flagRd[WDT_BIT] = wdtFlag;
  end

  assign pcLoadZero = pcQ;
  assign wdtDisable = wdQ;
endmodule

// File: rtl/rst_sequencer.sv
module rst_sequencer
  import rst_seq_pkg::*;
#(
  parameter int STATES  = 4,
  parameter int CONFIRM = 2,
  parameter int HOLD_MC = 2,
  parameter int FLAG_W  = 8
) (
  input  logic              clk,
  input  logic              porN,
  input  logic              rstPin,
  input  logic              wdtRstReq,
  input  logic              regWrEn,
  input  logic [FLAG_W-1:0] regWrData,
  output logic [FLAG_W-1:0] flagRd,
  output logic              coreRst,
  output logic              pcLoadZero,
  output logic              wdtDisable
);
  logic       sampleEdge;
  seqStrobe_t strobes;

  rst_seq_phase #(.STATES(STATES)) uPhase (
    .clk(clk), .porN(porN), .lastState(sampleEdge)
  );

  rst_seq_ctrl #(.STATES(STATES), .CONFIRM(CONFIRM), .HOLD_MC(HOLD_MC)) uCtrl (
    .clk(clk), .porN(porN), .sampleEdge(sampleEdge), .rstPin(rstPin),
    .wdtRstReq(wdtRstReq), .coreRst(coreRst), .strobes(strobes)
  );

  rst_seq_flags #(.FLAG_W(FLAG_W)) uFlags (
    .clk(clk), .porN(porN), .strobes(strobes), .regWrEn(regWrEn),
    .regWrData(regWrData), .flagRd(flagRd), .pcLoadZero(pcLoadZero),
    .wdtDisable(wdtDisable)
  );
endmodule

// File: rtl/rst_sequencer_checker.sv
module rst_sequencer_checker #(
  parameter int FW = 8
) (
  input logic          clk,
  input logic          porN,
  input logic          wdtRstReq,
  input logic          regWrEn,
  input logic [FW-1:0] regWrData,
  input logic [FW-1:0] flagRd,
  input logic          coreRst,
  input logic          pcLoadZero,
  input logic          wdtDisable
);
  assert_wdt_reset_R4: assert property (@(posedge clk) disable iff (!porN)
    wdtRstReq |=> coreRst);

  assert_wdt_flag_set_R8: assert property (@(posedge clk) disable iff (!porN)
    wdtRstReq |=> flagRd[1]);

  assert_upper_zero_R8: assert property (@(posedge clk) disable iff (!porN)
    flagRd[FW-1:2] == '0);

  assert_pc_on_release_R6: assert property (@(posedge clk) disable iff (!porN)
    $fell(coreRst) |-> pcLoadZero);

  assert_pc_single_R6: assert property (@(posedge clk) disable iff (!porN)
    pcLoadZero |=> !pcLoadZero);

  assert_wdtdis_paired_R7: assert property (@(posedge clk) disable iff (!porN)
    wdtDisable |-> pcLoadZero);

  assert_por_clear_R9: assert property (@(posedge clk) disable iff (!porN)
    (regWrEn && !regWrData[0]) |=> !flagRd[0]);

  assert_write_one_keeps_R9: assert property (@(posedge clk) disable iff (!porN)
    (regWrEn && regWrData[0] && flagRd[0]) |=> flagRd[0]);

  assert_no_spurious_wdt_R10: assert property (@(posedge clk) disable iff (!porN)
    (!wdtRstReq && !flagRd[1]) |=> !flagRd[1]);
endmodule

bind rst_sequencer rst_sequencer_checker #(.FW(FLAG_W)) uChk (
  .clk(clk), .porN(porN), .wdtRstReq(wdtRstReq), .regWrEn(regWrEn),
  .regWrData(regWrData), .flagRd(flagRd), .coreRst(coreRst),
  .pcLoadZero(pcLoadZero), .wdtDisable(wdtDisable)
);

// File: tb/rst_sequencer_test.sv
`timescale 1ns/1ps
module rst_sequencer_test;
  logic       clk = 1'b0;
  logic       porN = 1'b0;
  logic       rstPin = 1'b0;
  logic       wdtRstReq = 1'b0;
  logic       regWrEn = 1'b0;
  logic [7:0] regWrData = 8'h00;
  logic [7:0] flagRd;
  logic       coreRst, pcLoadZero, wdtDisable;
  int         vectors = 0;
  int         miscompares = 0;
  int         edgeN = 0;

  always #4 clk = ~clk;

  rst_sequencer uut (
    .clk(clk), .porN(porN), .rstPin(rstPin), .wdtRstReq(wdtRstReq),
    .regWrEn(regWrEn), .regWrData(regWrData), .flagRd(flagRd),
    .coreRst(coreRst), .pcLoadZero(pcLoadZero), .wdtDisable(wdtDisable)
  );

  // Rising edges since power-on release; sampling edges are multiples of 4
  always @(posedge clk or negedge porN) begin
    if (!porN) edgeN <= 0;
    else       edgeN <= edgeN + 1;
  end

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s actual=%0h expected=%0h at edge %0d", req, act, exp, edgeN);
    end
  endtask

  task automatic writeFlags(logic [7:0] d);
    regWrEn = 1'b1; regWrData = d;
    tick();
    regWrEn = 1'b0; regWrData = 8'h00;
  endtask

  task automatic powerOn();
    porN = 1'b0;
    tick(); tick();
    check("R5 coreRst in por", coreRst, 1);
    check("R5 flags in por", flagRd, 8'h01);
    check("R5 pc strobe in por", pcLoadZero, 0);
    check("R5 wdt strobe in por", wdtDisable, 0);
    porN = 1'b1;
    for (int k = 1; k <= 10; k++) begin
      tick();
      check("R5 por hold", coreRst, (k < 8) ? 1 : 0);
      check("R6 pc after por", pcLoadZero, (k == 8) ? 1 : 0);
      check("R7 wdt disable after por", wdtDisable, (k == 8) ? 1 : 0);
    end
  endtask

  // Pin high for edges s .. s+len-1, with s at the requested phase
  task automatic pinPulse(int ph, int len);
    int s, c1, cLast, cnt, rise, fall;
    logic [7:0] flagsBefore;
    flagsBefore = flagRd;
    s = edgeN + 1;
    while ((s % 4) != ph) s++;
    c1 = ((s + 3) / 4) * 4;
    cLast = ((s + len - 1) / 4) * 4;
    cnt = (cLast >= c1) ? ((cLast - c1) / 4 + 1) : 0;
    rise = c1 + 4;
    fall = cLast + 11;
    while (edgeN < s + len + 16) begin
      int n;
      n = edgeN + 1;
      rstPin = (n >= s && n <= s + len - 1);
      tick();
      if (cnt >= 2) begin
        check("R2 R3 pin reset window", coreRst, (n >= rise && n < fall) ? 1 : 0);
        check("R6 pc after pin", pcLoadZero, (n == fall) ? 1 : 0);
      end else begin
        check("R1 R2 short pulse ignored", coreRst, 0);
        check("R1 no pc strobe", pcLoadZero, 0);
      end
      check("R7 no wdt disable on pin", wdtDisable, 0);
    end
    rstPin = 1'b0;
    check("R8 R10 pin leaves flags", flagRd, flagsBefore);
  endtask

  task automatic wdtPulse(int ph);
    int s;
    s = edgeN + 1;
    while ((s % 4) != ph) s++;
    while (edgeN < s + 12) begin
      int n;
      n = edgeN + 1;
      wdtRstReq = (n == s);
      tick();
      check("R4 wdt reset window", coreRst, (n >= s && n < s + 8) ? 1 : 0);
      check("R6 pc after wdt", pcLoadZero, (n == s + 8) ? 1 : 0);
      check("R7 no wdt disable on wdt", wdtDisable, 0);
      if (n == s) check("R8 wdt flag set", flagRd[1], 1);
    end
    wdtRstReq = 1'b0;
  endtask

  initial begin
    #(8 * 150000);
    miscompares++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    @(negedge clk);
    powerOn();

    // R9: a 1 bit leaves the power-on flag, a 0 bit clears it
    writeFlags(8'h01);
    check("R9 write one keeps", flagRd, 8'h01);
    writeFlags(8'hFE);
    check("R9 write zero clears", flagRd, 8'h00);
    writeFlags(8'hFF);
    check("R9 write ones no set", flagRd, 8'h00);

    // R1 R2 R3: every start phase against pulse lengths
    for (int ph = 0; ph < 4; ph++) begin
      for (int len = 1; len <= 12; len++) pinPulse(ph, len);
      pinPulse(ph, 20);
    end

    // R4 R8: watchdog at every phase, then selective clear
    for (int ph = 0; ph < 4; ph++) begin
      wdtPulse(ph);
      check("R8 flags after wdt", flagRd, 8'h02);
      writeFlags(8'h01);
      check("R9 clear wdt flag", flagRd, 8'h00);
    end

    // R9: set outranks a clearing write at the same edge
    wdtRstReq = 1'b1; regWrEn = 1'b1; regWrData = 8'h00;
    tick();
    wdtRstReq = 1'b0; regWrEn = 1'b0;
    check("R9 set wins over clear", flagRd, 8'h02);
    for (int k = 0; k < 10; k++) tick();

    // R10: flag survives a pin reset
    pinPulse(1, 9);
    check("R10 sticky through pin", flagRd, 8'h02);

    // R5: second power-on replaces flags
    powerOn();
    check("R5 flags after repeat por", flagRd, 8'h01);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule